// File: doc/BRIEF.md
# Windowed Watchdog Timer with Timed Reconfiguration Lock

This block is a 16-bit watchdog timer for a chip's system-control area. Software sets it up through a small word-wide register port: a control/status word, a command word (read back as the live counter), a 16-bit timeout limit and a 16-bit window limit. Once enabled, the counter advances on a tick taken from one of four tick-enable inputs. It can optionally advance only once every 256 ticks. When it reaches the limit, the block either asserts its reset output at once, or first raises an interrupt and asserts the reset a fixed number of clocks later.

Software keeps the system alive by writing a two-word refresh key to the command word, which returns the counter to zero. Any wrong command word is treated as a fault. With the window enabled, a refresh that arrives before the counter has reached the window limit is also a fault. Both kinds of fault follow the same interrupt-then-delay rule as a timeout.

Configuration is held behind a lock. It is open for a bounded number of clocks after reset, and it closes as soon as the control word is written. It can be reopened for the same bounded period with a two-word unlock key, but only if that was permitted at configuration time. Three mode inputs (stop, wait, debug) halt counting unless the matching run-enable bit is set. A byte-lane self-test setting compares only one byte of the counter with the same byte of the limit.

Top module: `watchdog_win`

## Requirements
- R1: After reset, `wdog_rst` and `irq` are 0. The counter reads 0, the timeout limit reads 0xFFFF and the window limit reads 0. The control word reads 0x2000: all configuration bits 0, bit 13 (unlocked) 1, bit 14 (configuration done) 0.
- R2: Control bit 0 enables counting. Addresses are 0 control, 1 command/counter, 2 timeout, 3 window. With a tick on every clock and interrupts off (control bit 1 = 0), the counter steps once per clock after the enabling write. `wdog_rst` rises T+1 clocks after the control write that enables a limit T, and it then stays high until reset.
- R3: With control bit 1 set, a timeout or fault sets the flag and `irq` on the clock after it is detected. `wdog_rst` follows RST_DLY clocks (default 128) after the flag.
- R4: Writing a control word with bit 12 set clears the flag, even while the block is locked. Writing bit 12 as 0 leaves the flag unchanged. The flag reads back at control bit 12.
- R5: With control bit 4 set, the counter advances once per 256 selected ticks: limit 1 times out after 257 clocks, and limit 2 after 513 clocks.
- R6: Control bits [8:7] select the compare. 00 and 01 compare all 16 bits. 10 compares only counter bits [7:0] with limit bits [7:0]. 11 compares only bits [15:8].
- R7: Control bits [6:5] = s make the counter advance only on `tick_src[s]`. The other three tick inputs have no effect.
- R8: While `mode_stop`, `mode_wait` or `mode_dbg` is high, counting halts unless control bit 9, 10 or 11 (respectively) is set.
- R9: Writing 0x02A6 and then 0x80B4 to address 1 clears the counter. While the block is enabled, any other word, or a wrong second word, asserts the fault at the same clock edge. While the block is disabled, a wrong word has no effect.
- R10: With control bit 3 set, a refresh whose second word lands while the counter is below the window limit is a fault. A refresh that lands with the counter equal to or above the limit is valid.
- R11: Writes to the control configuration bits, the timeout limit or the window limit take effect only while the block is unlocked. It is unlocked for UNLOCK_CYC clocks after reset or after an unlock; a control write ends this at once (bit 13 goes to 0 and bit 14 to 1).
- R12: Writing 0xC520 and then 0xD928 to address 1 unlocks the block for exactly UNLOCK_CYC clocks (bit 13 = 1, bit 14 = 0), but only when control bit 2 was set. Otherwise the key is accepted as harmless and the block stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| tick_src | input | 4 | Tick-enable inputs, one per clock source |
| mode_stop | input | 1 | Chip in stop mode |
| mode_wait | input | 1 | Chip in wait mode |
| mode_dbg | input | 1 | Chip in debug mode |
| irq | output | 1 | Early-warning interrupt |
| wdog_rst | output | 1 | Watchdog reset request, sticky |

## Verification
A wrong counter state shows up at the ports as a reset edge one or more clocks away from the T+1 point, so the bench sweeps limits and measures that latency exactly. A command decoder stuck between the two words turns a later valid key into an immediate reset. A lock timer that is off by one shows in the status bit read one clock before and one clock after the UNLOCK_CYC boundary. The window compare is probed on both sides of its limit, and a bad interrupt delay shows up as a reset RST_DLY clocks off the measured flag edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;
  localparam logic [1:0] A_WIN  = 2'd3;

  localparam logic [DATA_W-1:0] K_REF1 = 16'h02A6;
  localparam logic [DATA_W-1:0] K_REF2 = 16'h80B4;
  localparam logic [DATA_W-1:0] K_UNL1 = 16'hC520;
  localparam logic [DATA_W-1:0] K_UNL2 = 16'hD928;

  localparam int FLAG_BIT = 12;

  // packed from MSB (bit 11) down to bit 0
  typedef struct packed {
    logic       run_dbg;
    logic       run_wait;
    logic       run_stop;
    logic [1:0] tmode;
    logic [1:0] csel;
    logic       div256;
    logic       win_en;
    logic       upd_ok;
    logic       irq_en;
    logic       en;
  } wdt_cfg_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REF, SQ_UNL} wdt_seq_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int UNLOCK_CYC = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdt_cfg_t          cfg,
  output logic [DATA_W-1:0] tov,
  output logic [DATA_W-1:0] win,
  output logic              unlocked,
  output logic              cfg_done,
  output logic              refresh_req,
  output logic              cmd_bad
);
  localparam int UW = (UNLOCK_CYC > 1) ? $clog2(UNLOCK_CYC) : 1;
  localparam logic [UW-1:0] ULK_LAST = UW'(UNLOCK_CYC - 1);

  wdt_seq_e          seq_q, seq_d;
  wdt_cfg_t          cfg_d;
  logic [DATA_W-1:0] tov_d, win_d;
  logic              unl_d, done_d, unlock_hit, cmd_wr;
  logic [UW-1:0]     ulk_q, ulk_d;

  assign cmd_wr = wr_en && (wr_addr == A_CMD);

  always_comb begin
    seq_d       = seq_q;
    refresh_req = 1'b0;
    unlock_hit  = 1'b0;
    cmd_bad     = 1'b0;
    if (cmd_wr) begin
      case (seq_q)
        SQ_IDLE: begin
          if (wr_data == K_REF1)      seq_d = SQ_REF;
          else if (wr_data == K_UNL1) seq_d = SQ_UNL;
          else                        cmd_bad = 1'b1;
        end
        SQ_REF: begin
          seq_d = SQ_IDLE;
          if (wr_data == K_REF2) refresh_req = 1'b1;
          else                   cmd_bad = 1'b1;
        end
        SQ_UNL: begin
          seq_d = SQ_IDLE;
          if (wr_data == K_UNL2) unlock_hit = 1'b1;
          else                   cmd_bad = 1'b1;
        end
        default: seq_d = SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    cfg_d  = cfg;
    tov_d  = tov;
    win_d  = win;
    unl_d  = unlocked;
    done_d = cfg_done;
    ulk_d  = unlocked ? ulk_q + 1'b1 : '0;
    if (unlocked && ulk_q == ULK_LAST) begin
      unl_d  = 1'b0;
      done_d = 1'b1;
    end
    if (wr_en && unlocked) begin
      case (wr_addr)
        A_CTRL: begin
          cfg_d  = wdt_cfg_t'(wr_data[11:0]);
          unl_d  = 1'b0;
          done_d = 1'b1;
        end
        A_TOV:   tov_d = wr_data;
        A_WIN:   win_d = wr_data;
        default: ;
      endcase
    end
    if (unlock_hit && cfg.upd_ok && !unlocked) begin
      unl_d  = 1'b1;
      done_d = 1'b0;
      ulk_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= SQ_IDLE;
      cfg      <= '0;
      tov      <= '1;
      win      <= '0;
      unlocked <= 1'b1;
      cfg_done <= 1'b0;
      ulk_q    <= '0;
    end else begin
      seq_q    <= seq_d;
      cfg      <= cfg_d;
      tov      <= tov_d;
      win      <= win_d;
      unlocked <= unl_d;
      cfg_done <= done_d;
      ulk_q    <= ulk_d;
    end
  end

  // R11
  locked_tov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TOV && !unlocked) |=> $stable(tov));
  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && cfg_done));
  // R12
  unlock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !cfg.upd_ok) |=> !unlocked);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        tick_src,
  input  logic              en,
  input  logic              div256,
  input  logic [1:0]        csel,
  input  logic [1:0]        tmode,
  input  logic              run_stop,
  input  logic              run_wait,
  input  logic              run_dbg,
  input  logic              mode_stop,
  input  logic              mode_wait,
  input  logic              mode_dbg,
  input  logic [DATA_W-1:0] tov,
  input  logic              clr,
  input  logic              hold,
  output logic [DATA_W-1:0] cnt,
  output logic              expire
);
  localparam int HB = DATA_W / 2;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DATA_W-1:0] cnt_d;
  logic              halted, step, inc, match;

  assign halted = (mode_stop && !run_stop) || (mode_wait && !run_wait) ||
                  (mode_dbg && !run_dbg);
  assign step   = en && tick_src[csel] && !halted && !hold;
  assign inc    = step && (!div256 || (&pre_q));

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt;
    if (!en || clr) begin
      pre_d = '0;
      cnt_d = '0;
    end else begin
      if (step) pre_d = pre_q + 1'b1;
      if (inc)  cnt_d = cnt + 1'b1;
    end
  end

  always_comb begin
    case (tmode)
      2'b10:   match = (cnt[HB-1:0] == tov[HB-1:0]);
      2'b11:   match = (cnt[DATA_W-1:HB] == tov[DATA_W-1:HB]);
      default: match = (cnt == tov);
    endcase
  end

  assign expire = en && match && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= pre_d;
      cnt   <= cnt_d;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));
  // R5
  prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div256 && !clr && pre_q != '1) |=> $stable(cnt));
endmodule

// File: rtl/wdt_fault.sv
module wdt_fault #(
  parameter int RST_DLY = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic irq_en,
  input  logic flag_clr,
  output logic flag,
  output logic pending,
  output logic wdog_rst
);
  localparam int DW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
  localparam logic [DW-1:0] DLY_LAST = DW'(RST_DLY - 1);

  logic          flag_d, pend_d, rst_d, idle;
  logic [DW-1:0] dly_q, dly_d;

  assign idle = !pending && !wdog_rst;

  always_comb begin
    flag_d = flag;
    pend_d = pending;
    rst_d  = wdog_rst;
    dly_d  = dly_q;
    if (flag_clr) flag_d = 1'b0;
    if (fault_in && idle) begin
      if (irq_en) begin
        flag_d = 1'b1;
        pend_d = 1'b1;
        dly_d  = '0;
      end else begin
        rst_d = 1'b1;
      end
    end
    if (pending && !wdog_rst) begin
      if (dly_q == DLY_LAST) rst_d = 1'b1;
      else                   dly_d = dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      pending  <= 1'b0;
      wdog_rst <= 1'b0;
      dly_q    <= '0;
    end else begin
      flag     <= flag_d;
      pending  <= pend_d;
      wdog_rst <= rst_d;
      dly_q    <= dly_d;
    end
  end

  // R2
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> wdog_rst);
  // R2
  direct_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !irq_en && idle) |=> wdog_rst);
  // R3
  early_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && irq_en && idle) |=> (flag && !wdog_rst));
endmodule

// File: rtl/watchdog_win.sv
module watchdog_win
  import wdt_pkg::*;
#(
  parameter int UNLOCK_CYC = 128,
  parameter int RST_DLY    = 128,
  parameter int PRE_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic [3:0]  tick_src,
  input  logic        mode_stop,
  input  logic        mode_wait,
  input  logic        mode_dbg,
  output logic        irq,
  output logic        wdog_rst
);
  logic [1:0]        rsync_q;
  logic              srst_n;
  wdt_cfg_t          cfg;
  logic [DATA_W-1:0] tov, win, cnt;
  logic              unlocked, cfg_done, refresh_req, cmd_bad;
  logic              expire, flag, pending, early, win_viol, fault, clr, flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  wdt_regs #(.UNLOCK_CYC(UNLOCK_CYC)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .tov(tov), .win(win),
    .unlocked(unlocked), .cfg_done(cfg_done),
    .refresh_req(refresh_req), .cmd_bad(cmd_bad)
  );

  assign early    = cfg.win_en && (cnt < win);
  assign win_viol = cfg.en && refresh_req && early;
  assign fault    = expire || (cfg.en && cmd_bad) || win_viol;
  assign clr      = refresh_req && !win_viol;
  assign flag_clr = wr_en && (wr_addr == A_CTRL) && wr_data[FLAG_BIT];

  wdt_count #(.PRE_W(PRE_W)) u_count (
    .clk(clk), .rst_n(srst_n), .tick_src(tick_src), .en(cfg.en),
    .div256(cfg.div256), .csel(cfg.csel), .tmode(cfg.tmode),
    .run_stop(cfg.run_stop), .run_wait(cfg.run_wait), .run_dbg(cfg.run_dbg),
    .mode_stop(mode_stop), .mode_wait(mode_wait), .mode_dbg(mode_dbg),
    .tov(tov), .clr(clr), .hold(pending || wdog_rst),
    .cnt(cnt), .expire(expire)
  );

  wdt_fault #(.RST_DLY(RST_DLY)) u_fault (
    .clk(clk), .rst_n(srst_n), .fault_in(fault), .irq_en(cfg.irq_en),
    .flag_clr(flag_clr), .flag(flag), .pending(pending), .wdog_rst(wdog_rst)
  );

  assign irq = flag && cfg.irq_en;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {1'b0, cfg_done, unlocked, flag, cfg};
      A_CMD:   rd_data = cnt;
      A_TOV:   rd_data = tov;
      default: rd_data = win;
    endcase
  end

  // R10
  early_refresh_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (refresh_req && cfg.en && cfg.win_en && cnt < win && !cfg.irq_en &&
     !pending && !wdog_rst) |=> wdog_rst);
endmodule

// File: tb/sim_watchdog_win.sv
module sim_watchdog_win;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [3:0]  tick_src;
  logic        mode_stop, mode_wait, mode_dbg, irq, wdog_rst;
  int          checks = 0, errors = 0;

  localparam logic [15:0] B_EN = 16'h0001, B_IRQ = 16'h0002, B_UPD = 16'h0004,
                          B_WIN = 16'h0008, B_DIV = 16'h0010, B_FLAG = 16'h1000;

  always #4 clk = ~clk;

  watchdog_win u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_src(tick_src), .mode_stop(mode_stop), .mode_wait(mode_wait),
    .mode_dbg(mode_dbg), .irq(irq), .wdog_rst(wdog_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    tick_src = 4'b0001; mode_stop = 0; mode_wait = 0; mode_dbg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic setup(input logic [15:0] tv, input logic [15:0] wn,
                       input logic [15:0] ctl);
    wr(2'd2, tv);
    wr(2'd3, wn);
    wr(2'd0, ctl);
  endtask

  task automatic lat(input int lim, output int n_rst, output int n_irq);
    int n = 0;
    n_irq = irq ? 0 : -1;
    while (!wdog_rst && n < lim) begin
      @(negedge clk);
      n++;
      if (irq && n_irq < 0) n_irq = n;
    end
    n_rst = wdog_rst ? n : -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, nr, ni;
    // R1 reset state
    do_reset();
    rd(2'd0, v); chk("R1 ctrl", v, 16'h2000);
    rd(2'd1, v); chk("R1 cnt", v, 0);
    rd(2'd2, v); chk("R1 tov", v, 16'hFFFF);
    rd(2'd3, v); chk("R1 win", v, 0);
    chk("R1 rst", int'(wdog_rst), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 timeout latency sweep
    for (int t = 0; t <= 20; t++) begin
      do_reset();
      setup(16'(t), 16'd0, B_EN);
      lat(100, nr, ni);
      chk("R2 timeout latency", nr, t + 1);
      repeat (3) @(negedge clk);
      chk("R2 rst sticky", int'(wdog_rst), 1);
    end

    // R3 interrupt then delayed reset
    do_reset();
    setup(16'd5, 16'd0, B_EN | B_IRQ);
    lat(400, nr, ni);
    chk("R3 irq edge", ni, 6);
    chk("R3 rst edge", nr, 6 + 128);

    // R4 flag write-one-to-clear while locked
    do_reset();
    setup(16'd1000, 16'd0, B_EN | B_IRQ);
    wr(2'd1, 16'h1234);
    chk("R4 flag set by fault", int'(irq), 1);
    wr(2'd0, 16'h0000);
    chk("R4 write 0 keeps flag", int'(irq), 1);
    wr(2'd0, B_FLAG);
    chk("R4 write 1 clears flag", int'(irq), 0);
    rd(2'd0, v); chk("R4 ctrl readback", v, 16'h4000 | int'(B_EN | B_IRQ));

    // R5 prescaler
    do_reset();
    setup(16'd1, 16'd0, B_EN | B_DIV);
    lat(600, nr, ni); chk("R5 div256 limit1", nr, 257);
    do_reset();
    setup(16'd2, 16'd0, B_EN | B_DIV);
    lat(600, nr, ni); chk("R5 div256 limit2", nr, 513);

    // R6 byte-lane compare modes
    for (int l = 1; l < 10; l += 4) begin
      do_reset();
      setup(16'h7700 | 16'(l), 16'd0, B_EN | (16'd2 << 7));
      lat(400, nr, ni); chk("R6 low lane", nr, l + 1);
    end
    do_reset();
    setup(16'h0100, 16'd0, B_EN | (16'd3 << 7));
    lat(400, nr, ni); chk("R6 high lane 0100", nr, 257);
    do_reset();
    setup(16'h01FF, 16'd0, B_EN | (16'd3 << 7));
    lat(400, nr, ni); chk("R6 high lane 01FF", nr, 257);
    do_reset();
    setup(16'd6, 16'd0, B_EN | (16'd1 << 7));
    lat(400, nr, ni); chk("R6 user mode full", nr, 7);

    // R7 tick source select
    for (int s = 0; s < 4; s++) begin
      do_reset();
      tick_src = 4'(1 << s);
      setup(16'd1000, 16'd0, B_EN | 16'(s << 5));
      repeat (10) @(negedge clk);
      rd(2'd1, v); chk("R7 selected tick counts", v, 10);
      tick_src = ~4'(1 << s);
      repeat (10) @(negedge clk);
      rd(2'd1, v); chk("R7 other ticks ignored", v, 10);
    end

    // R8 low-power / debug mode gating
    for (int b = 0; b < 3; b++) begin
      for (int on = 0; on < 2; on++) begin
        do_reset();
        mode_stop = (b == 0); mode_wait = (b == 1); mode_dbg = (b == 2);
        setup(16'd1000, 16'd0, B_EN | (on != 0 ? 16'(1 << (9 + b)) : 16'd0));
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk("R8 mode gating", v, on != 0 ? 10 : 0);
      end
    end

    // R9 refresh and bad commands
    do_reset();
    setup(16'd50, 16'd0, B_EN);
    repeat (20) @(negedge clk);
    wr(2'd1, 16'h02A6); wr(2'd1, 16'h80B4);
    rd(2'd1, v); chk("R9 refresh clears", v, 0);
    repeat (45) @(negedge clk);
    rd(2'd1, v); chk("R9 count after refresh", v, 45);
    chk("R9 no reset after refresh", int'(wdog_rst), 0);
    do_reset();
    setup(16'd1000, 16'd0, B_EN);
    wr(2'd1, 16'h1234);
    chk("R9 bad word", int'(wdog_rst), 1);
    do_reset();
    setup(16'd1000, 16'd0, B_EN);
    wr(2'd1, 16'h02A6); wr(2'd1, 16'h1111);
    chk("R9 bad second word", int'(wdog_rst), 1);
    do_reset();
    setup(16'd1000, 16'd0, B_EN);
    wr(2'd1, 16'hC520); wr(2'd1, 16'h80B4);
    chk("R9 mixed keys", int'(wdog_rst), 1);
    do_reset();
    setup(16'd1000, 16'd0, 16'd0);
    wr(2'd1, 16'h1234);
    repeat (2) @(negedge clk);
    chk("R9 disabled ignores bad word", int'(wdog_rst), 0);

    // R10 refresh window boundary
    for (int k = 2; k <= 9; k++) begin
      if (k != 2 && k != 8 && k != 9) continue;
      do_reset();
      setup(16'd100, 16'd10, B_EN | B_WIN);
      repeat (k) @(negedge clk);
      wr(2'd1, 16'h02A6); wr(2'd1, 16'h80B4);
      chk("R10 window refresh", int'(wdog_rst), (k + 1 < 10) ? 1 : 0);
    end
    do_reset();
    setup(16'd100, 16'd10, B_EN);
    repeat (2) @(negedge clk);
    wr(2'd1, 16'h02A6); wr(2'd1, 16'h80B4);
    chk("R10 window off early ok", int'(wdog_rst), 0);

    // R11 lock after configuration
    do_reset();
    setup(16'd300, 16'd0, B_EN);
    rd(2'd0, v); chk("R11 status locked", v & 16'h6000, 16'h4000);
    wr(2'd2, 16'd5);
    rd(2'd2, v); chk("R11 tov ignored", v, 300);
    wr(2'd0, 16'h0FF0);
    rd(2'd0, v); chk("R11 ctrl ignored", v & 16'h0FFF, 1);
    wr(2'd3, 16'd9);
    rd(2'd3, v); chk("R11 win ignored", v, 0);

    // R12 timed unlock
    do_reset();
    setup(16'd100, 16'd0, B_UPD);
    wr(2'd1, 16'hC520); wr(2'd1, 16'hD928);
    rd(2'd0, v); chk("R12 unlocked status", v & 16'h6000, 16'h2000);
    wr(2'd2, 16'd77);
    rd(2'd2, v); chk("R12 write while unlocked", v, 77);
    wr(2'd0, B_UPD | B_EN);
    rd(2'd0, v); chk("R12 ctrl write relocks", v & 16'h6FFF, 16'h4000 | int'(B_UPD | B_EN));
    do_reset();
    setup(16'd100, 16'd0, B_UPD);
    wr(2'd1, 16'hC520); wr(2'd1, 16'hD928);
    repeat (127) @(negedge clk);
    rd(2'd0, v); chk("R12 open at last cycle", (v >> 13) & 1, 1);
    @(negedge clk);
    rd(2'd0, v); chk("R12 closed after window", v & 16'h6000, 16'h4000);
    wr(2'd2, 16'd5);
    rd(2'd2, v); chk("R12 write after expiry ignored", v, 100);
    do_reset();
    setup(16'd1000, 16'd0, B_EN);
    wr(2'd1, 16'hC520); wr(2'd1, 16'hD928);
    rd(2'd0, v); chk("R12 no unlock without permit", (v >> 13) & 1, 0);
    chk("R12 key harmless", int'(wdog_rst), 0);
    wr(2'd2, 16'd5);
    rd(2'd2, v); chk("R12 still locked", v, 1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule